// File: doc/BRIEF.md
# Keyboard Wake Frame Detector

This block listens to the clock and data wires of a PS/2-style keyboard while the system sleeps. It samples both wires on a slow 32 kHz clock, frames each 11-bit keyboard transmission and checks it. When the frame is well formed and its byte equals a programmed key code, the block raises a wake event. Each frame holds a start bit (0), eight data bits sent least significant bit first, an odd parity bit and a stop bit (1). Data is taken on every falling edge of the keyboard clock, once that clock has passed through a two-flop synchronizer.

The frame state machine has three states. In `ST_IDLE` it waits for the first falling edge, which takes the start bit. `ST_IDLE -> ST_RECV` happens on that edge. In `ST_RECV` it collects the remaining bits. `ST_RECV -> ST_EVAL` happens on the eleventh falling edge. `ST_RECV -> ST_IDLE` is the stall abort: the keyboard clock has stayed high for five 32 kHz ticks (about 153 us, longer than one keyboard clock period) before the frame is complete. `ST_EVAL` lasts one cycle, in which the frame is judged. `ST_EVAL -> ST_IDLE` follows unconditionally, so detection carries on frame after frame.

A disable input with inverted sense switches the feature. At 0 (the expected setting after reset) the detector runs. At 1 the logic is frozen as if its clock were stopped, and no wake can be produced. A separate PME enable gates the wake event. The wake is a one-cycle pulse, and it also sets a sticky flag. Software clears the flag by driving a clear input to 1.

Top module: `kbd_wake_detector`

## Requirements
- R1: After reset, `wake_pulse` and `wake_sticky` are 0.
- R2: A frame starts on the first falling edge of the synchronized keyboard clock seen in idle. The frame is judged on the eleventh falling edge, and the detector then returns to idle. Frames sent one after another are each judged.
- R3: Bit positions are as follows. Frame bit 0 is the start bit and must be 0. Bits 1..8 carry the data byte, least significant bit first. Bit 9 is parity: the nine bits 1..9 must hold an odd number of ones. Bit 10 is the stop bit and must be 1. A frame that meets all of these and whose byte equals `match_code` produces exactly one `wake_pulse` of one cycle, provided `pme_en` is 1 and `feat_off` is 0.
- R4: A frame with a start bit of 1, a stop bit of 0, even parity, or a byte different from `match_code` produces no pulse.
- R5: Inside a frame, a high phase of 5 or more consecutive 32 kHz cycles on the keyboard clock aborts the partial frame, and its bits are discarded. A high phase of 4 cycles or fewer does not abort the frame.
- R6: While `feat_off` is 1, no pulse is produced and the framing state does not advance. Any keyboard activity during that time is ignored. When `feat_off` returns to 0, a partial frame continues from where it stopped.
- R7: With `pme_en` at 0, a matching frame produces no pulse and leaves `wake_sticky` unchanged.
- R8: `wake_sticky` becomes 1 one cycle after a pulse. It returns to 0 one cycle after `status_clr` is 1 with no pulse present. When a pulse and `status_clr` arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk32 | input | 1 | 32 kHz sampling clock |
| rst_n | input | 1 | Active-low reset |
| feat_off | input | 1 | Feature disable: 0 runs the detector, 1 freezes it |
| pme_en | input | 1 | Enables the wake event |
| status_clr | input | 1 | Write-1 clear of the sticky flag |
| match_code | input | 8 | Key code that triggers a wake |
| kb_clk | input | 1 | Keyboard clock wire (asynchronous) |
| kb_data | input | 1 | Keyboard data wire (asynchronous) |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_sticky | output | 1 | Latched wake status |

## Verification
The wake pulse that sets the sticky flag and a software clear can arrive in the same cycle. The bench provokes this by holding `status_clr` at 1 for the whole of a matching frame. It then samples `wake_sticky` one cycle after the pulse and expects 1, and expects 0 once the frame has passed. A second collision is the stall timer reaching its limit as a frame resumes. This is judged with gaps of exactly four and five high cycles, and by freezing the detector partway through a frame while garbage keeps toggling.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_EVAL = 2'd2
    } kwd_state_e;

    localparam int FRAME_LEN  = 11;
    localparam int STALL_TICK = 5;
    localparam int CODE_W     = 8;
endpackage

// File: rtl/kwd_sync.sv
module kwd_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= RST_VAL[g];
                stage2[g] <= RST_VAL[g];
            end else if (en) begin
                stage1[g] <= async_in[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/kwd_frame_fsm.sv
module kwd_frame_fsm
    import kwd_pkg::*;
#(
    parameter int FRAME_BITS    = FRAME_LEN,
    parameter int TIMEOUT_TICKS = STALL_TICK
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  kclk_s,
    input  logic                  kdat_s,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] frame_bits
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int TO_W  = $clog2(TIMEOUT_TICKS + 1);

    kwd_state_e            state, state_nx;
    logic [CNT_W-1:0]      bit_cnt;
    logic [TO_W-1:0]       hi_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  kclk_prev;
    logic                  fall;
    logic                  stall;

    always_comb begin
        fall  = kclk_prev & ~kclk_s;
        stall = (state == ST_RECV) && kclk_s && (hi_cnt == TO_W'(TIMEOUT_TICKS - 1));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (fall) state_nx = ST_RECV;
            ST_RECV: begin
                if (stall)
                    state_nx = ST_IDLE;
                else if (fall && bit_cnt == CNT_W'(FRAME_BITS - 1))
                    state_nx = ST_EVAL;
            end
            ST_EVAL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (en)
            state <= state_nx;
    end

    // datapath: edge history, bit shifting, bit and stall counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kclk_prev <= 1'b1;
            bit_cnt   <= '0;
            hi_cnt    <= '0;
            shreg     <= '0;
        end else if (en) begin
            kclk_prev <= kclk_s;
            if (fall && (state == ST_IDLE || state == ST_RECV)) begin
                shreg   <= {kdat_s, shreg[FRAME_BITS-1:1]};
                bit_cnt <= (state == ST_IDLE) ? CNT_W'(1) : bit_cnt + CNT_W'(1);
            end
            if (state == ST_RECV && kclk_s && !stall)
                hi_cnt <= hi_cnt + TO_W'(1);
            else
                hi_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        frame_done = (state == ST_EVAL);
        frame_bits = shreg;
    end

    // R2
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // R2
    eval_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_EVAL) |=> (state == ST_IDLE));

    // R5
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt < TO_W'(TIMEOUT_TICKS));

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(state) && $stable(bit_cnt) && $stable(shreg)));
endmodule

// File: rtl/kwd_match.sv
module kwd_match
    import kwd_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_LEN,
    parameter int DW         = CODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  pme_en,
    input  logic                  status_clr,
    input  logic                  frame_done,
    input  logic [FRAME_BITS-1:0] frame_bits,
    input  logic [DW-1:0]         match_code,
    output logic                  wake_pulse,
    output logic                  wake_sticky
);
    logic          start_ok;
    logic          stop_ok;
    logic          par_ok;
    logic          byte_ok;
    logic          hit;
    logic [DW-1:0] rx_byte;

    always_comb begin
        rx_byte  = frame_bits[DW:1];
        start_ok = ~frame_bits[0];
        stop_ok  = frame_bits[FRAME_BITS-1];
        par_ok   = ^frame_bits[DW+1:1];
        byte_ok  = (rx_byte == match_code);
        hit      = start_ok & stop_ok & par_ok & byte_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_pulse <= 1'b0;
        else
            wake_pulse <= en & pme_en & frame_done & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_sticky <= 1'b0;
        else
            wake_sticky <= wake_pulse | (wake_sticky & ~status_clr);
    end

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R6
    off_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wake_pulse);

    // R7
    pme_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_en |=> !wake_pulse);

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> wake_sticky);

    // R8
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !wake_pulse) |=> !wake_sticky);
endmodule

// File: rtl/kbd_wake_detector.sv
module kbd_wake_detector
    import kwd_pkg::*;
#(
    parameter int FRAME_BITS    = FRAME_LEN,
    parameter int TIMEOUT_TICKS = STALL_TICK,
    parameter int DW            = CODE_W
) (
    input  logic          clk32,
    input  logic          rst_n,
    input  logic          feat_off,
    input  logic          pme_en,
    input  logic          status_clr,
    input  logic [DW-1:0] match_code,
    input  logic          kb_clk,
    input  logic          kb_data,
    output logic          wake_pulse,
    output logic          wake_sticky
);
    logic                  run_en;
    logic [1:0]            wires_s;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_bits;

    assign run_en = ~feat_off;

    kwd_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk      (clk32),
        .rst_n    (rst_n),
        .en       (run_en),
        .async_in ({kb_data, kb_clk}),
        .sync_out (wires_s)
    );

    kwd_frame_fsm #(.FRAME_BITS(FRAME_BITS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_fsm (
        .clk        (clk32),
        .rst_n      (rst_n),
        .en         (run_en),
        .kclk_s     (wires_s[0]),
        .kdat_s     (wires_s[1]),
        .frame_done (frame_done),
        .frame_bits (frame_bits)
    );

    kwd_match #(.FRAME_BITS(FRAME_BITS), .DW(DW)) u_match (
        .clk         (clk32),
        .rst_n       (rst_n),
        .en          (run_en),
        .pme_en      (pme_en),
        .status_clr  (status_clr),
        .frame_done  (frame_done),
        .frame_bits  (frame_bits),
        .match_code  (match_code),
        .wake_pulse  (wake_pulse),
        .wake_sticky (wake_sticky)
    );
endmodule

// File: tb/kbd_wake_detector_tb.sv
module kbd_wake_detector_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk32 = 1'b0;
    logic       rst_n = 1'b0;
    logic       feat_off = 1'b0;
    logic       pme_en = 1'b1;
    logic       status_clr = 1'b0;
    logic [7:0] match_code = 8'h00;
    logic       kb_clk = 1'b1;
    logic       kb_data = 1'b1;
    logic       wake_pulse;
    logic       wake_sticky;

    int n_checks = 0;
    int n_fail = 0;
    int pulse_cnt = 0;
    logic pulse_d = 1'b0;
    logic sticky_after = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk32 = ~clk32;

    kbd_wake_detector u_dut (
        .clk32(clk32), .rst_n(rst_n), .feat_off(feat_off), .pme_en(pme_en),
        .status_clr(status_clr), .match_code(match_code), .kb_clk(kb_clk),
        .kb_data(kb_data), .wake_pulse(wake_pulse), .wake_sticky(wake_sticky)
    );

    always @(negedge clk32) begin
        if (pulse_d) sticky_after = wake_sticky;
        if (wake_pulse) pulse_cnt++;
        pulse_d = wake_pulse;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] make_frame(input logic [7:0] d, input bit bs,
                                               input bit bp, input bit bst);
        logic [10:0] f;
        f[0]   = bs;
        f[8:1] = d;
        f[9]   = (~^d) ^ bp;
        f[10]  = ~bst;
        return f;
    endfunction

    task automatic send_range(input logic [10:0] f, input int lo, input int hi_idx, input int hi);
        for (int i = lo; i <= hi_idx; i++) begin
            kb_clk  = 1'b1;
            kb_data = f[i];
            repeat (hi) @(negedge clk32);
            kb_clk = 1'b0;
            repeat (2) @(negedge clk32);
        end
        kb_clk = 1'b1;
    endtask

    task automatic idle(input int n);
        kb_clk = 1'b1;
        repeat (n) @(negedge clk32);
    endtask

    task automatic clear_sticky();
        status_clr = 1'b1;
        @(negedge clk32);
        status_clr = 1'b0;
        @(negedge clk32);
    endtask

    initial begin
        logic [10:0] f;
        void'($urandom(32'h1234_5eed));
        repeat (4) @(negedge clk32);
        chk(wake_pulse == 1'b0, "R1 pulse", int'(wake_pulse), 0);
        chk(wake_sticky == 1'b0, "R1 sticky", int'(wake_sticky), 0);
        rst_n = 1'b1;
        idle(4);
        chk(wake_pulse == 1'b0 && wake_sticky == 1'b0, "R1 after release", int'(wake_sticky), 0);

        // R3 directed match
        match_code = 8'hA5;
        pulse_cnt = 0;
        send_range(make_frame(8'hA5, 0, 0, 0), 0, 10, 2);
        idle(8);
        chk(pulse_cnt == 1, "R3 match pulse", pulse_cnt, 1);
        chk(wake_sticky == 1'b1, "R8 sticky set", int'(wake_sticky), 1);
        clear_sticky();
        chk(wake_sticky == 1'b0, "R8 sticky clear", int'(wake_sticky), 0);

        // R2 back to back frames
        pulse_cnt = 0;
        send_range(make_frame(8'hA5, 0, 0, 0), 0, 10, 1);
        send_range(make_frame(8'hA5, 0, 0, 0), 0, 10, 1);
        idle(8);
        chk(pulse_cnt == 2, "R2 back to back", pulse_cnt, 2);
        clear_sticky();

        // R4 corruptions
        for (int m = 1; m <= 4; m++) begin
            pulse_cnt = 0;
            f = make_frame((m == 4) ? 8'hA4 : 8'hA5, m == 1, m == 2, m == 3);
            send_range(f, 0, 10, 2);
            idle(8);
            chk(pulse_cnt == 0, "R4 bad frame", pulse_cnt, 0);
        end
        chk(wake_sticky == 1'b0, "R4 sticky untouched", int'(wake_sticky), 0);

        // R5 gap of 4 keeps frame
        pulse_cnt = 0;
        f = make_frame(8'hA5, 0, 0, 0);
        send_range(f, 0, 4, 2);
        send_range(f, 5, 10, 4);
        idle(8);
        chk(pulse_cnt == 1, "R5 gap4 keeps", pulse_cnt, 1);
        clear_sticky();

        // R5 gap of 5 aborts
        pulse_cnt = 0;
        send_range(f, 0, 4, 2);
        idle(5);
        send_range(f, 0, 10, 2);
        idle(8);
        chk(pulse_cnt == 1, "R5 gap5 aborts", pulse_cnt, 1);
        clear_sticky();

        // R7 pme disabled
        pme_en = 1'b0;
        pulse_cnt = 0;
        send_range(f, 0, 10, 2);
        idle(8);
        chk(pulse_cnt == 0, "R7 no pulse", pulse_cnt, 0);
        chk(wake_sticky == 1'b0, "R7 sticky", int'(wake_sticky), 0);
        pme_en = 1'b1;

        // R6 full frame while off
        feat_off = 1'b1;
        pulse_cnt = 0;
        send_range(f, 0, 10, 2);
        idle(8);
        chk(pulse_cnt == 0, "R6 off no pulse", pulse_cnt, 0);
        feat_off = 1'b0;
        idle(4);
        send_range(f, 0, 10, 2);
        idle(8);
        chk(pulse_cnt == 1, "R6 resume idle", pulse_cnt, 1);
        clear_sticky();

        // R6 freeze mid frame, garbage ignored
        pulse_cnt = 0;
        send_range(f, 0, 4, 2);
        @(negedge clk32);
        feat_off = 1'b1;
        send_range(make_frame(8'h3C, 1, 1, 1), 0, 10, 2);
        idle(3);
        feat_off = 1'b0;
        send_range(f, 5, 10, 2);
        idle(8);
        chk(pulse_cnt == 1, "R6 freeze continue", pulse_cnt, 1);
        clear_sticky();

        // R8 pulse and clear in same cycle
        status_clr = 1'b1;
        pulse_cnt = 0;
        sticky_after = 1'b0;
        send_range(f, 0, 10, 2);
        idle(8);
        chk(pulse_cnt == 1, "R8 pulse with clr", pulse_cnt, 1);
        chk(sticky_after == 1'b1, "R8 set wins", int'(sticky_after), 1);
        chk(wake_sticky == 1'b0, "R8 cleared later", int'(wake_sticky), 0);
        status_clr = 1'b0;
        idle(2);

        // R3 R4 R7 random frames
        for (int it = 0; it < 30; it++) begin
            logic [7:0] code;
            logic [7:0] dat;
            int mode;
            int gap;
            bit pm;
            bit exp_hit;
            code = 8'($urandom());
            mode = int'($urandom_range(0, 4));
            gap  = int'($urandom_range(1, 4));
            pm   = 1'($urandom_range(0, 3) != 0);
            dat  = (mode == 4) ? (code ^ (8'h01 << $urandom_range(0, 7))) : code;
            exp_hit = (mode == 0) && pm;
            match_code = code;
            pme_en = pm;
            pulse_cnt = 0;
            send_range(make_frame(dat, mode == 1, mode == 2, mode == 3), 0, 10, gap);
            idle(8);
            chk(pulse_cnt == int'(exp_hit), "R3 R4 R7 random pulse", pulse_cnt, int'(exp_hit));
            chk(wake_sticky == exp_hit, "R8 random sticky", int'(wake_sticky), int'(exp_hit));
            clear_sticky();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk32);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule